// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block takes six active-low external interrupt pins and one non-maskable interrupt pin from outside the chip and turns them into clean request signals for a processor core. Every input is first brought into the core clock domain. Each of the six pins then has its own trigger condition, chosen in a 16-bit control register: a rising edge, a falling edge, or a held low level. An edge leaves a sticky pending flag, and software clears that flag by writing a one to the pin's bit in a separate clear register. A level request follows the pin and keeps no memory.

At run time, the four lowest pins can be regrouped into one 4-bit priority code that gives fifteen request levels. In that mode their individual requests are silenced, and the two upper pins stay independent. The non-maskable input raises a held request on its falling edge, and an acknowledge strobe clears it. Two control bits set the masking rules: one lets a low non-maskable pin hide all ordinary requests, and the other decides whether the core's block bit can hold back the non-maskable request.

The register bus is a single write strobe with a one-bit select that picks the control register or the clear register. The control register is always visible on the read-data output.

Top module: `ext_irq_sense`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, the control register reads 0x4000 and irq_req, irl_level and nmi_req are all zero.
- R2: A write with reg_sel=0 stores all 16 bits of reg_wdata into the control register, and the new value is visible on reg_rdata after that clock edge. Bit 12 is stored but changes no behaviour.
- R3: The trigger field of pin i sits in control bits [2i+1:2i]. The codes are 00 for a falling edge, 01 for a rising edge, and 10 or 11 for a low level. In an edge mode, a qualifying edge sets a sticky request on irq_req[i]. That request appears on the third rising clock edge after the pin changes and stays set after the pin returns.
- R4: In low-level mode, irq_req[i] is 1 while the pin is low and 0 while it is high, with the same three-edge latency and no memory.
- R5: A write with reg_sel=1 clears the pending request of every pin i whose reg_wdata[i] is 1, and irq_req[i] is 0 right after that edge. When a clear and a new edge meet in the same cycle, the clear wins.
- R6: A control write that changes pin i's trigger field clears that pin's pending flag. A write that leaves the field unchanged keeps it.
- R7: When control bit 14 is 1, irq_req[3:0] is 0 and irl_level equals 15 minus the synchronized pin value {irq_pin[3:0]}, so 1111 gives 0 (no request) and 0000 gives 15. Pins 4 and 5 keep working independently. When bit 14 is 0, irl_level is 0.
- R8: When control bit 15 is 1 and the synchronized non-maskable pin is low, irq_req and irl_level are forced to 0. When bit 15 is 0, a low non-maskable pin masks nothing.
- R9: A falling edge on nmi_pin sets a held request. nmi_req shows it three clock edges after the pin falls, and a one-cycle nmi_ack clears it at the next edge.
- R10: When control bit 13 is 0, nmi_req is held at 0 while cpu_block is 1, and the request stays pending until cpu_block drops. When bit 13 is 1, nmi_req ignores cpu_block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the clear register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current control register contents |
| irq_pin | input | 6 | External interrupt pins, active low |
| nmi_pin | input | 1 | Non-maskable interrupt pin, active low |
| cpu_block | input | 1 | Block bit from the processor status |
| nmi_ack | input | 1 | Acknowledge strobe for the non-maskable request |
| irq_req | output | 6 | Per-pin request outputs |
| irl_level | output | 4 | Encoded priority level, 0 means no request |
| nmi_req | output | 1 | Non-maskable request |

## Verification
A change on any pin reaches irq_req, irl_level or nmi_req on the third rising edge: two synchronizer edges, then the registered output. A register write, a clear write or an acknowledge acts on the edge that samples it. A change on cpu_block shows on nmi_req one edge later. The bench drives every input on a falling edge and counts the rising edges up to the one where a result is due. It then samples on the following falling edge. The first edge-trigger test also samples one edge early, to confirm that the request has not yet appeared.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int CTRL_W = 16;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h4000;
  localparam int BIT_MASK_ALL = 15;
  localparam int BIT_ENC_MODE = 14;
  localparam int BIT_NMI_ANY  = 13;

  typedef enum logic [1:0] {
    TRIG_FALL    = 2'b00,
    TRIG_RISE    = 2'b01,
    TRIG_LOW     = 2'b10,
    TRIG_LOW_ALT = 2'b11
  } trig_e;

  function automatic logic trig_is_level(input logic [1:0] f);
    return (f == TRIG_LOW) || (f == TRIG_LOW_ALT);
  endfunction
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '1;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/eis_pin.sv
module eis_pin
  import eis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_s,
  input  logic [1:0] trig,
  input  logic       hold_off,
  input  logic       clr,
  input  logic       retrig,
  output logic       req_next
);
  logic prev_q, pend_q, pend_next;
  logic fall, rise, hit, level;

  assign level = trig_is_level(trig);
  assign fall  = prev_q & ~pin_s;
  assign rise  = ~prev_q & pin_s;

  always_comb begin
    case (trig)
      TRIG_FALL: hit = fall;
      TRIG_RISE: hit = rise;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    if (hold_off || clr || retrig || level) pend_next = 1'b0;
    else                                    pend_next = pend_q | hit;
  end

  assign req_next = level ? ~pin_s : pend_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_next;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pend_q); // R5
  AST_RETRIG_DROPS: assert property (@(posedge clk) disable iff (rst)
    retrig |=> !pend_q); // R6
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr && !retrig && !hold_off && !level) |=> pend_q); // R3
endmodule

// File: rtl/eis_nmi.sv
module eis_nmi (
  input  logic clk,
  input  logic rst,
  input  logic nmi_s,
  input  logic ack,
  input  logic accept_any,
  input  logic cpu_block,
  output logic req_next
);
  logic prev_q, pend_q, pend_next, fall;

  assign fall      = prev_q & ~nmi_s;
  assign pend_next = fall ? 1'b1 : (ack ? 1'b0 : pend_q);
  assign req_next  = pend_next & (accept_any | ~cpu_block);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_s;
      pend_q <= pend_next;
    end
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack) |=> pend_q); // R9
  AST_NMI_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && !fall) |=> !pend_q); // R9
endmodule

// File: rtl/eis_level_enc.sv
module eis_level_enc #(
  parameter int N_ENC = 4
) (
  input  logic [N_ENC-1:0] pins_s,
  output logic [N_ENC-1:0] level
);
  localparam logic [N_ENC-1:0] LVL_MAX = '1;
  assign level = LVL_MAX - pins_s;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int N_IRQ       = 6,
  parameter int N_ENC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic [N_IRQ-1:0]  irq_pin,
  input  logic              nmi_pin,
  input  logic              cpu_block,
  input  logic              nmi_ack,
  output logic [N_IRQ-1:0]  irq_req,
  output logic [N_ENC-1:0]  irl_level,
  output logic              nmi_req
);
  localparam int SYNC_W = N_IRQ + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, wr_clr;
  logic [SYNC_W-1:0] pins_s;
  logic [N_IRQ-1:0]  irq_s, req_vec, hold_vec;
  logic              nmi_s, enc_mode, mask_all, nmi_next;
  logic [N_ENC-1:0]  enc_level;

  assign wr_ctrl = reg_wr & ~reg_sel;
  assign wr_clr  = reg_wr & reg_sel;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= CTRL_RESET;
    else if (wr_ctrl) ctrl_q <= reg_wdata;
  end
  assign reg_rdata = ctrl_q;

  eis_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({nmi_pin, irq_pin}), .q(pins_s)
  );
  assign irq_s = pins_s[N_IRQ-1:0];
  assign nmi_s = pins_s[N_IRQ];

  assign enc_mode = ctrl_q[BIT_ENC_MODE];
  assign mask_all = ctrl_q[BIT_MASK_ALL] & ~nmi_s;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
    localparam bit IN_GROUP = (i < N_ENC);
    assign hold_vec[i] = enc_mode & IN_GROUP;
    eis_pin u_pin (
      .clk(clk), .rst(rst), .pin_s(irq_s[i]),
      .trig(ctrl_q[2*i +: 2]),
      .hold_off(hold_vec[i]),
      .clr(wr_clr & reg_wdata[i]),
      .retrig(wr_ctrl & (reg_wdata[2*i +: 2] != ctrl_q[2*i +: 2])),
      .req_next(req_vec[i])
    );
  end

  eis_level_enc #(.N_ENC(N_ENC)) u_enc (
    .pins_s(irq_s[N_ENC-1:0]), .level(enc_level)
  );

  eis_nmi u_nmi (
    .clk(clk), .rst(rst), .nmi_s(nmi_s), .ack(nmi_ack),
    .accept_any(ctrl_q[BIT_NMI_ANY]), .cpu_block(cpu_block),
    .req_next(nmi_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= '0;
      irl_level <= '0;
      nmi_req   <= 1'b0;
    end else begin
      irq_req   <= mask_all ? '0 : (req_vec & ~hold_vec);
      irl_level <= (mask_all || !enc_mode) ? '0 : enc_level;
      nmi_req   <= nmi_next;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (reg_rdata == CTRL_RESET && irq_req == '0 && irl_level == '0 && !nmi_req)); // R1
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> reg_rdata == $past(reg_wdata)); // R2
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
    mask_all |=> (irq_req == '0 && irl_level == '0)); // R8
  AST_ENC_QUIET: assert property (@(posedge clk) disable iff (rst)
    enc_mode |=> irq_req[N_ENC-1:0] == '0); // R7
  AST_IRL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enc_mode |=> irl_level == '0); // R7
  AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[BIT_NMI_ANY] && cpu_block) |=> !nmi_req); // R10
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [5:0]  irq_pin = '1;
  logic        nmi_pin = 1'b1, cpu_block = 1'b0, nmi_ack = 1'b0;
  logic [5:0]  irq_req;
  logic [3:0]  irl_level;
  logic        nmi_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
    .nmi_pin(nmi_pin), .cpu_block(cpu_block), .nmi_ack(nmi_ack),
    .irq_req(irq_req), .irl_level(irl_level), .nmi_req(nmi_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    nmi_ack = 1'b1;
    @(negedge clk);
    nmi_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl reset", reg_rdata, 16'h4000);
    check("R1 irq_req reset", 16'(irq_req), 16'h0);
    check("R1 irl reset", 16'(irl_level), 16'h0);
    check("R1 nmi reset", 16'(nmi_req), 16'h0);
  endtask

  task automatic t_regs();
    write_reg(1'b0, 16'h3AAA);
    check("R2 readback", reg_rdata, 16'h3AAA);
    write_reg(1'b0, 16'h0000);
    check("R2 readback zero", reg_rdata, 16'h0000);
  endtask

  task automatic t_fall_edge();
    irq_pin[0] = 1'b0;
    wait_cyc(2);
    check("R3 not before third edge", 16'(irq_req[0]), 16'h0);
    wait_cyc(1);
    check("R3 falling edge", 16'(irq_req[0]), 16'h1);
    irq_pin[0] = 1'b1;
    wait_cyc(4);
    check("R3 sticky", 16'(irq_req[0]), 16'h1);
    write_reg(1'b1, 16'h0001);
    check("R5 clear", 16'(irq_req), 16'h0);
  endtask

  task automatic t_rise_edge();
    write_reg(1'b0, 16'h0010);
    irq_pin[2] = 1'b0;
    wait_cyc(4);
    check("R3 rising ignores fall", 16'(irq_req[2]), 16'h0);
    irq_pin[2] = 1'b1;
    wait_cyc(3);
    check("R3 rising edge", 16'(irq_req[2]), 16'h1);
    write_reg(1'b1, 16'h0004);
    check("R5 clear pin2", 16'(irq_req[2]), 16'h0);
  endtask

  task automatic t_retrig();
    write_reg(1'b0, 16'h0000);
    irq_pin[1] = 1'b0;
    wait_cyc(3);
    check("R3 pin1 fall", 16'(irq_req[1]), 16'h1);
    irq_pin[1] = 1'b1;
    wait_cyc(3);
    write_reg(1'b0, 16'h0004);
    check("R6 field change clears", 16'(irq_req[1]), 16'h0);
    wait_cyc(3);
    check("R6 stays clear", 16'(irq_req[1]), 16'h0);
    irq_pin[3] = 1'b0;
    wait_cyc(3);
    irq_pin[3] = 1'b1;
    write_reg(1'b0, 16'h1004);
    wait_cyc(3);
    check("R6 R2 unchanged field and bit 12 keep pending", 16'(irq_req[3]), 16'h1);
    write_reg(1'b1, 16'h0008);
    check("R5 clear pin3", 16'(irq_req), 16'h0);
  endtask

  task automatic t_level();
    write_reg(1'b0, 16'h0200);
    irq_pin[4] = 1'b0;
    wait_cyc(3);
    check("R4 level low", 16'(irq_req[4]), 16'h1);
    irq_pin[4] = 1'b1;
    wait_cyc(3);
    check("R4 level released", 16'(irq_req[4]), 16'h0);
  endtask

  task automatic t_encoded();
    write_reg(1'b0, 16'h4000);
    irq_pin[3:0] = 4'b0000;
    wait_cyc(3);
    check("R7 level 15", 16'(irl_level), 16'h000F);
    check("R7 low pins quiet", 16'(irq_req[3:0]), 16'h0);
    irq_pin[3:0] = 4'b0101;
    wait_cyc(3);
    check("R7 level 10", 16'(irl_level), 16'h000A);
    irq_pin[5] = 1'b0;
    wait_cyc(3);
    check("R7 pin5 independent", 16'(irq_req[5]), 16'h1);
    irq_pin[3:0] = 4'b1111;
    irq_pin[5] = 1'b1;
    wait_cyc(3);
    check("R7 idle code", 16'(irl_level), 16'h0);
    write_reg(1'b1, 16'h0020);
    write_reg(1'b0, 16'h0000);
    wait_cyc(1);
    check("R7 independent irl zero", 16'(irl_level), 16'h0);
  endtask

  task automatic t_mask();
    write_reg(1'b0, 16'h8200);
    irq_pin[4] = 1'b0;
    wait_cyc(3);
    check("R8 level before mask", 16'(irq_req[4]), 16'h1);
    nmi_pin = 1'b0;
    wait_cyc(3);
    check("R8 masked", 16'(irq_req[4]), 16'h0);
    check("R9 nmi set", 16'(nmi_req), 16'h1);
    nmi_pin = 1'b1;
    wait_cyc(3);
    check("R8 unmasked", 16'(irq_req[4]), 16'h1);
    check("R9 nmi held", 16'(nmi_req), 16'h1);
    pulse_ack();
    check("R9 ack clears", 16'(nmi_req), 16'h0);
    write_reg(1'b0, 16'h0200);
    nmi_pin = 1'b0;
    wait_cyc(3);
    check("R8 no mask when bit clear", 16'(irq_req[4]), 16'h1);
    nmi_pin = 1'b1;
    irq_pin[4] = 1'b1;
    wait_cyc(3);
    pulse_ack();
  endtask

  task automatic t_block();
    write_reg(1'b0, 16'h0000);
    cpu_block = 1'b1;
    nmi_pin = 1'b0;
    wait_cyc(3);
    check("R10 blocked", 16'(nmi_req), 16'h0);
    nmi_pin = 1'b1;
    wait_cyc(2);
    cpu_block = 1'b0;
    wait_cyc(1);
    check("R10 pending released", 16'(nmi_req), 16'h1);
    pulse_ack();
    write_reg(1'b0, 16'h2000);
    cpu_block = 1'b1;
    nmi_pin = 1'b0;
    wait_cyc(3);
    check("R10 accepted regardless", 16'(nmi_req), 16'h1);
    nmi_pin = 1'b1;
    pulse_ack();
    check("R9 ack clears again", 16'(nmi_req), 16'h0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_fall_edge();
    t_rise_edge();
    t_retrig();
    t_level();
    t_encoded();
    t_mask();
    t_block();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule